// File: doc/BRIEF.md
# Power and Sleep Sequencing Controller

This block is a register-mapped controller that owns a few power domains and a larger set of clock-gated modules. Each module belongs to one domain, fixed by a parameter table. Software writes the desired state of every module and domain into control words. It then starts a transition for one or more domains by writing a one-hot bit mask to a command word. While a domain is in transition, its bit in a transition status word stays high. Module and domain status words show the state actually reached.

A domain that is off and is asked to come on goes through two handshakes. First the block raises a request to an external power switch and waits for its acknowledge. Next it flags the domain as awaiting power-good and waits for software to write an acknowledge bit. Only then does the domain report on and let its modules move. A domain asked to go off moves its modules first, then reports off and drops its switch request.

All registers are 32-bit words on a byte-addressed port with a stride of 4. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `psc_regs`

## Requirements
- R1: After reset, every domain reports on (domain status word reads 1, domain control reads 1, switch request high). Every module reports state 0 with its clock stopped. Module control words read 0x100, which means local reset is released and force is clear. The pending word (0x070) and the transition status word (0x128) read 0.
- R2: Offsets that map to no register read 0. This includes module or domain indices beyond the configured count. The command word (0x120) reads 0. Writes to the status words (0x128, 0x200+4n, 0x800+4n) change nothing.
- R3: Module control word n sits at 0xA00+4n. Bits [1:0] store the requested state (0 soft-reset-disable, 1 sync reset, 2 disable, 3 enable), and bits [5:2] are not stored and read 0. Bit 8 is the active-low local reset, and it drives output `mod_lrst_n[n]` directly. Bit 31 is the force flag.
- R4: Writing 1 to bit d of 0x120 while domain d is idle, with the domain on or staying off, sets bit d of 0x128 at that edge. The bit stays set for MOD_CYCLES edges. At the last of those edges, every module of domain d takes its requested state. Modules of other domains are unaffected.
- R5: Module status word n (0x800+4n) shows the current state in bits [1:0]. Bit 12 is set, and `mod_clk_en[n]` is high, exactly when that state is 3 (enable).
- R6: A module whose force flag is set takes its requested state one edge after the transition starts, instead of at its end.
- R7: Powering up an off domain d works in four steps. (1) `pwr_req[d]` rises at the command edge, and nothing else happens until `pwr_ack[d]` is seen. (2) Bit d of 0x070 then sets, and the block waits for bit 8 of domain control d (0x300+4d) to be written 1. (3) One edge after that write, the pending bit clears, the domain status reads 1 and the acknowledge bit clears itself. (4) The module phase of R4 then runs.
- R8: A transition with bit 0 of domain control d clear, on a domain that is on, runs the module phase first. At its final edge the domain status becomes 0 and `pwr_req[d]` falls.
- R9: A command bit for a domain that is already in transition is ignored and does not restart or lengthen it.
- R10: Domain status word d (0x200+4d) reads 1 when the domain is on and 0 when it is off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| pwr_ack | input | NUM_DOM | Power switch acknowledge per domain |
| pwr_req | output | NUM_DOM | Power switch request per domain |
| mod_clk_en | output | NUM_MOD | Clock enable per module (state enable) |
| mod_lrst_n | output | NUM_MOD | Active-low local reset per module |

## Verification
A phase register that slips or sticks shows up at once in the transition status word. That word is read on each cycle of a transition, so a phase of the wrong length or a restart by a second command appears within a cycle of the expected end. A wrong module update, or one in the wrong domain, shows in the module status words and the clock enables on the cycle after the final edge. A forced module is sampled at the very first cycle, so an early or late update is seen there. The power-up path is held at each handshake for several cycles, so a sequencer that skips a wait exposes the pending bit or the domain status early.

// File: rtl/psc_regs.sv
`timescale 1ns/1ps
module psc_regs #(
  parameter int NUM_DOM = 2,
  parameter int NUM_MOD = 8,
  parameter int MOD_CYCLES = 4,
  parameter logic [4*NUM_MOD-1:0] MOD_DOM_MAP = 32'h1111_0000,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [NUM_DOM-1:0] pwr_ack,
  output logic [NUM_DOM-1:0] pwr_req,
  output logic [NUM_MOD-1:0] mod_clk_en,
  output logic [NUM_MOD-1:0] mod_lrst_n
);

  localparam int PEND_OFS = 'h070;
  localparam int CMD_OFS  = 'h120;
  localparam int TST_OFS  = 'h128;
  localparam int DST_OFS  = 'h200;
  localparam int DCTL_OFS = 'h300;
  localparam int MST_OFS  = 'h800;
  localparam int MCTL_OFS = 'hA00;
  localparam int CNT_W = (MOD_CYCLES > 1) ? $clog2(MOD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MOD_CYCLES - 1);
  localparam logic [1:0] ST_ENABLE = 2'd3;

  typedef enum logic [1:0] {PH_IDLE, PH_PWR, PH_PG, PH_MOD} ph_t;

  ph_t              ph      [NUM_DOM];
  logic [CNT_W-1:0] cnt     [NUM_DOM];
  logic [NUM_DOM-1:0] dom_on, dom_nxt, dom_ack, pend, busy;
  logic [1:0]       mod_cur [NUM_MOD];
  logic [1:0]       mod_nxt [NUM_MOD];
  logic [NUM_MOD-1:0] mod_frc, mod_lrn, mod_upd;
  logic             cmd_wr;
  logic             unused_bits;

  assign cmd_wr = wr_en && (addr == ADDR_W'(CMD_OFS));
  assign unused_bits = ^{wdata[30:9], wdata[7:2]};
  assign mod_lrst_n = mod_lrn;

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(PEND_OFS)) rdata[NUM_DOM-1:0] = pend;
    if (addr == ADDR_W'(TST_OFS))  rdata[NUM_DOM-1:0] = busy;
    for (int d = 0; d < NUM_DOM; d++) begin
      if (addr == ADDR_W'(DST_OFS + 4*d)) rdata[0] = dom_on[d];
      if (addr == ADDR_W'(DCTL_OFS + 4*d)) begin
        rdata[0] = dom_nxt[d];
        rdata[8] = dom_ack[d];
      end
    end
    for (int m = 0; m < NUM_MOD; m++) begin
      if (addr == ADDR_W'(MST_OFS + 4*m)) begin
        rdata[1:0] = mod_cur[m];
        rdata[12]  = mod_clk_en[m];
      end
      if (addr == ADDR_W'(MCTL_OFS + 4*m)) begin
        rdata[1:0] = mod_nxt[m];
        rdata[8]   = mod_lrn[m];
        rdata[31]  = mod_frc[m];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dom_on  <= '1;
      dom_nxt <= '1;
      dom_ack <= '0;
      pend    <= '0;
      for (int d = 0; d < NUM_DOM; d++) begin
        ph[d]  <= PH_IDLE;
        cnt[d] <= '0;
      end
      for (int m = 0; m < NUM_MOD; m++) begin
        mod_cur[m] <= '0;
        mod_nxt[m] <= '0;
      end
      mod_frc <= '0;
      mod_lrn <= '1;
    end else begin
      if (wr_en) begin
        for (int d = 0; d < NUM_DOM; d++)
          if (addr == ADDR_W'(DCTL_OFS + 4*d)) begin
            dom_nxt[d] <= wdata[0];
            dom_ack[d] <= wdata[8];
          end
        for (int m = 0; m < NUM_MOD; m++)
          if (addr == ADDR_W'(MCTL_OFS + 4*m)) begin
            mod_nxt[m] <= wdata[1:0];
            mod_lrn[m] <= wdata[8];
            mod_frc[m] <= wdata[31];
          end
      end
      for (int d = 0; d < NUM_DOM; d++) begin
        case (ph[d])
          PH_IDLE:
            if (cmd_wr && wdata[d]) begin
              cnt[d] <= '0;
              if (dom_nxt[d] && !dom_on[d]) ph[d] <= PH_PWR;
              else                          ph[d] <= PH_MOD;
            end
          PH_PWR:
            if (pwr_ack[d]) begin
              ph[d]   <= PH_PG;
              pend[d] <= 1'b1;
            end
          PH_PG:
            if (dom_ack[d]) begin
              pend[d]    <= 1'b0;
              dom_on[d]  <= 1'b1;
              dom_ack[d] <= 1'b0;
              cnt[d]     <= '0;
              ph[d]      <= PH_MOD;
            end
          default: begin
            cnt[d] <= cnt[d] + 1'b1;
            if (cnt[d] == CNT_LAST) begin
              ph[d] <= PH_IDLE;
              if (!dom_nxt[d]) dom_on[d] <= 1'b0;
            end
          end
        endcase
      end
      for (int m = 0; m < NUM_MOD; m++)
        if (mod_upd[m]) mod_cur[m] <= mod_nxt[m];
    end
  end

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    assign busy[d]    = (ph[d] != PH_IDLE);
    assign pwr_req[d] = dom_on[d] || (ph[d] == PH_PWR) || (ph[d] == PH_PG);

    // R7
    dom_on_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(dom_on[d]) |-> $past(ph[d] == PH_PG && dom_ack[d]));
    // R7
    pend_only_waiting_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend[d] |-> (ph[d] == PH_PG));
    // R8
    pwr_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pwr_req[d]) |-> $past(ph[d] == PH_MOD && !dom_nxt[d]));
    // R4
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy[d]) |-> $past(ph[d] == PH_MOD && cnt[d] == CNT_LAST));
    // R9
    cmd_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ph[d] == PH_PWR && !pwr_ack[d] && cmd_wr && wdata[d]) |=> (ph[d] == PH_PWR));
  end

  for (genvar m = 0; m < NUM_MOD; m++) begin : g_mod
    localparam int D = int'(MOD_DOM_MAP[4*m +: 4]);
    assign mod_upd[m] = (ph[D] == PH_MOD) &&
                        ((mod_frc[m] && cnt[D] == '0) || cnt[D] == CNT_LAST);
    assign mod_clk_en[m] = (mod_cur[m] == ST_ENABLE);

    // R4
    mod_move_in_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_cur[m] != $past(mod_cur[m])) |-> $past(ph[D] == PH_MOD));
  end

endmodule

// File: tb/psc_regs_bench.sv
`timescale 1ns/1ps
module psc_regs_bench;
  localparam logic [11:0] PEND = 12'h070, CMD = 12'h120, TST = 12'h128;
  localparam logic [11:0] DST0 = 12'h200, DST1 = 12'h204, DCTL0 = 12'h300, DCTL1 = 12'h304;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [1:0] pwr_ack = '0;
  logic [31:0] rdata;
  logic [1:0] pwr_req;
  logic [7:0] mod_clk_en, mod_lrst_n;

  int vectors = 0, miscompares = 0;
  bit finished = 1'b0;
  logic [31:0] exp_q[$];
  string tag_q[$];
  event mon_ev;

  always #5 clk = ~clk;

  psc_regs u_psc_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pwr_ack(pwr_ack), .pwr_req(pwr_req),
    .mod_clk_en(mod_clk_en), .mod_lrst_n(mod_lrst_n)
  );

  function automatic logic [11:0] mst(input int m);
    return 12'(12'h800 + 4*m);
  endfunction
  function automatic logic [11:0] mctl(input int m);
    return 12'(12'hA00 + 4*m);
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    addr = a;
    exp_q.push_back(e);
    tag_q.push_back(t);
    #1 ->mon_ev;
    @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] e, input string t);
    vectors++;
    if (act !== e) begin
      miscompares++;
      $display("FAIL %s: got %h expected %h", t, act, e);
    end
  endtask

  task automatic wait_idle(input string t);
    for (int i = 0; i < 60; i++) begin
      addr = TST;
      #1;
      if (rdata == 32'h0) break;
      @(negedge clk);
    end
    rd(TST, 32'h0, t);
  endtask

  initial begin
    forever begin
      @(mon_ev);
      begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rdata, e, t);
      end
    end
  end

  task automatic report;
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog (all): got timeout expected completion");
      report();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(DST0, 32'h1, "R1 dom0 status");
    rd(DST1, 32'h1, "R1 dom1 status");
    rd(DCTL0, 32'h1, "R1 dom0 control");
    rd(mst(0), 32'h0, "R1 mod0 status");
    rd(mctl(5), 32'h100, "R1 mod5 control");
    rd(TST, 32'h0, "R1 transition status");
    rd(PEND, 32'h0, "R1 pending");
    chk(32'(pwr_req), 32'h3, "R1 pwr_req");
    chk(32'(mod_lrst_n), 32'hFF, "R1 mod_lrst_n");
    chk(32'(mod_clk_en), 32'h0, "R1 mod_clk_en");

    // R2 decode
    rd(12'h004, 32'h0, "R2 unmapped");
    rd(12'h208, 32'h0, "R2 domain index beyond range");
    rd(12'h820, 32'h0, "R2 module index beyond range");
    rd(CMD, 32'h0, "R2 command reads zero");
    wr(mst(1), 32'hFFFF_FFFF);
    wr(TST, 32'hFFFF_FFFF);
    wr(DST0, 32'h0);
    rd(mst(1), 32'h0, "R2 module status write ignored");
    rd(TST, 32'h0, "R2 transition status write ignored");
    rd(DST0, 32'h1, "R2 domain status write ignored");

    // R3 control fields
    wr(mctl(2), 32'h8000_003E);
    rd(mctl(2), 32'h8000_0002, "R3 force, state, lreset asserted");
    chk(32'(mod_lrst_n), 32'hFB, "R3 mod_lrst_n follows bit 8");
    wr(mctl(2), 32'h0000_0102);
    chk(32'(mod_lrst_n), 32'hFF, "R3 local reset released");

    // R4 / R5 timed transition of domain 0
    wr(mctl(0), 32'h103);
    wr(mctl(1), 32'h102);
    wr(mctl(4), 32'h103);
    wr(CMD, 32'h1);
    rd(TST, 32'h1, "R4 busy after command");
    rd(mst(0), 32'h0, "R4 mod0 not yet moved");
    rd(mst(1), 32'h0, "R4 mod1 not yet moved");
    rd(TST, 32'h1, "R4 busy on last cycle");
    rd(TST, 32'h0, "R4 busy cleared after MOD_CYCLES");
    rd(mst(0), 32'h1003, "R5 mod0 enabled with clock bit");
    rd(mst(1), 32'h2, "R4 mod1 disabled");
    rd(mst(2), 32'h2, "R4 mod2 disabled");
    rd(mst(4), 32'h0, "R4 other domain untouched");
    chk(32'(mod_clk_en), 32'h01, "R5 mod_clk_en");

    // R6 force
    wr(mctl(3), 32'h8000_0103);
    wr(CMD, 32'h1);
    rd(mst(3), 32'h0, "R6 forced module before first edge");
    rd(mst(3), 32'h1003, "R6 forced module moved early");
    wait_idle("R6 transition done");
    chk(32'(mod_clk_en), 32'h09, "R5 mod_clk_en after force");

    // R9 repeat command while busy
    wr(CMD, 32'h2);
    wr(CMD, 32'h2);
    rd(TST, 32'h2, "R9 busy");
    rd(TST, 32'h2, "R9 busy");
    rd(TST, 32'h2, "R9 busy last cycle");
    rd(TST, 32'h0, "R9 second command did not extend");
    rd(mst(4), 32'h1003, "R4 domain 1 module enabled");

    // R8 power down domain 1
    wr(mctl(4), 32'h100);
    wr(DCTL1, 32'h0);
    wr(CMD, 32'h2);
    chk(32'(pwr_req), 32'h3, "R8 request held during module phase");
    wait_idle("R8 transition done");
    rd(DST1, 32'h0, "R10 domain 1 off");
    chk(32'(pwr_req), 32'h1, "R8 pwr_req dropped");
    rd(mst(4), 32'h0, "R8 module moved before power off");

    // R7 power up domain 1
    wr(DCTL1, 32'h1);
    wr(CMD, 32'h2);
    chk(32'(pwr_req), 32'h3, "R7 request raised");
    rd(TST, 32'h2, "R7 busy");
    repeat (3) @(negedge clk);
    rd(PEND, 32'h0, "R7 no pending before switch ack");
    pwr_ack = 2'b10;
    @(negedge clk);
    rd(PEND, 32'h2, "R7 pending set after switch ack");
    repeat (4) @(negedge clk);
    rd(PEND, 32'h2, "R7 still waiting software ack");
    rd(DST1, 32'h0, "R10 domain 1 still off");
    wr(DCTL1, 32'h101);
    rd(PEND, 32'h2, "R7 pending until next edge");
    rd(PEND, 32'h0, "R7 pending cleared");
    rd(DST1, 32'h1, "R10 domain 1 on");
    rd(DCTL1, 32'h1, "R7 acknowledge self-cleared");
    wait_idle("R7 power-up done");
    pwr_ack = 2'b00;
    chk(32'(pwr_req), 32'h3, "R7 request stays on");

    report();
  end
endmodule